// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the programmer-visible register state of a small 16-bit processor core. Two copies of a seven-register group exist side by side: four 16-bit data registers, two address registers and a frame base. A single copy of the shared state sits next to them: a 20-bit program counter, a 20-bit interrupt table base, a user stack pointer, an interrupt stack pointer, a static base and a 16-bit flag word. One bit of the flag word chooses which banked copy every access reaches. A second bit chooses which physical stack pointer answers to the "active stack pointer" select code.

The decode stage drives two independent read ports and one write port. Each port carries a 4-bit register select and a 2-bit access size. The lower two data registers can be reached as separate bytes. Each of them can also be paired with the data register two places above it to form a 32-bit value. Reads are combinational from the stored state. Writes land on the rising clock edge. Reset comes in asynchronously and is released through a two-stage synchronizer. The program counter takes its start address from an input port.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and after it is released, with no write yet made, every banked register, both stack pointers, the static base, the interrupt table base and the flag word read as zero. The program counter reads the value on `pc_rst_val`.
- R2: Select codes: 0–3 data registers D0–D3, 4–5 address registers, 6 frame base, 7 program counter, 8 interrupt table upper 4 bits, 9 interrupt table lower 16 bits, 10 active stack pointer, 11 user stack pointer, 12 interrupt stack pointer, 13 static base, 14 flags, 15 unused. A word access (size 0) writes the low bits of `wr_data` that fit the target. It reads the target zero-extended to 32 bits. A write to code 15 changes nothing, and a read of code 15 returns zero.
- R3: For D0 and D1, size 1 writes `wr_data[7:0]` into bits 7:0 only, and size 2 writes `wr_data[7:0]` into bits 15:8 only. A read of size 1 or 2 returns the addressed byte in bits 7:0 with zeros above it. For any other select, sizes 1 and 2 act as a word access.
- R4: Size 3 on D0 addresses the 32-bit pair {D2,D0}, and on D1 the pair {D3,D1}. A pair write updates both registers in the same clock edge. A pair read returns the upper register in bits 31:16.
- R5: Flag bit 4 selects the bank for codes 0–6 (0 = bank zero, 1 = bank one). The bank that is not selected keeps its contents.
- R6: Code 10 reaches the user stack pointer when flag bit 7 is 1 and the interrupt stack pointer when it is 0. Codes 11 and 12 reach each pointer directly, whatever the flag.
- R7: Only flag bits 7:0 and 14:12 are stored. Bits 11:8 and 15 read as zero and ignore writes. `flag_o` shows the stored flag word.
- R8: A read of a register in the same cycle as a write to it returns the old value. A flag write that changes bit 4 or bit 7 first affects accesses in the next cycle.
- R9: The program counter, interrupt table base, stack pointers, static base and flags read the same whichever bank is selected.
- R10: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_rst_val | input | 20 | Program counter start address |
| ra_sel | input | 4 | Read port A register select |
| ra_size | input | 2 | Read port A access size |
| ra_data | output | 32 | Read port A data |
| rb_sel | input | 4 | Read port B register select |
| rb_size | input | 2 | Read port B access size |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register select |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data |
| flag_o | output | 16 | Stored flag word |
| pc_o | output | 20 | Current program counter |

## Verification
The bench writes a byte into one half of D0 and reads the other half back. A design that wrote the whole word would show the new byte in both halves or zeros in the half it should keep. It writes a pair and reads the upper register alone, which catches swapped halves or a missing partner update. It flips the bank and stack-select bits and reads the same select code in the flip cycle and in the cycle after. A design that forwarded the new flags early, or that wrote the wrong bank or stack pointer, returns another register's contents. It also writes all ones to the flag word and to the unused select code, which exposes reserved bits that are not masked and a stray write to code 15.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DW      = 16;
  localparam int AW      = 20;
  localparam int BW      = 8;
  localparam int RDW     = 2 * DW;
  localparam int NDATA   = 4;
  localparam int NADDR   = 2;
  localparam int NBANK   = 2;
  localparam int SELW    = 4;
  localparam int SZW     = 2;
  localparam int ITBH_W  = AW - DW;
  localparam int NBYTE   = NDATA / 2;

  localparam int FLG_BANK = 4;
  localparam int FLG_USTK = 7;
  localparam logic [DW-1:0] FLG_MASK = 16'h70FF;

  typedef enum logic [SELW-1:0] {
    SEL_D0   = 4'd0,
    SEL_D1   = 4'd1,
    SEL_D2   = 4'd2,
    SEL_D3   = 4'd3,
    SEL_AX0  = 4'd4,
    SEL_AX1  = 4'd5,
    SEL_FB   = 4'd6,
    SEL_PC   = 4'd7,
    SEL_ITBH = 4'd8,
    SEL_ITBL = 4'd9,
    SEL_SP   = 4'd10,
    SEL_USTK = 4'd11,
    SEL_ISTK = 4'd12,
    SEL_SB   = 4'd13,
    SEL_FLG  = 4'd14,
    SEL_NONE = 4'd15
  } rsel_e;

  typedef enum logic [SZW-1:0] {
    SZ_WORD = 2'd0,
    SZ_LO   = 2'd1,
    SZ_HI   = 2'd2,
    SZ_PAIR = 2'd3
  } rsize_e;

  typedef struct packed {
    logic [NDATA-1:0][DW-1:0] d;
    logic [NADDR-1:0][DW-1:0] ax;
    logic [DW-1:0]            fb;
  } bank_t;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] sel,
  input  logic [SZW-1:0]  size,
  input  logic [RDW-1:0]  wdata,
  output bank_t           q
);
  bank_t  q_r;
  bank_t  nxt;
  rsize_e sz;

  assign sz = rsize_e'(size);

  always_comb begin
    nxt = q_r;
    for (int i = 0; i < NDATA; i++) begin
      if (int'(sel) == i) begin
        if (i < NBYTE && sz == SZ_LO) begin
          nxt.d[i][BW-1:0] = wdata[BW-1:0];
        end else if (i < NBYTE && sz == SZ_HI) begin
          nxt.d[i][2*BW-1:BW] = wdata[BW-1:0];
        end else if (i < NBYTE && sz == SZ_PAIR) begin
          nxt.d[i]                     = wdata[DW-1:0];
          nxt.d[(i + NBYTE) % NDATA]   = wdata[RDW-1:DW];
        end else begin
          nxt.d[i] = wdata[DW-1:0];
        end
      end
    end
    for (int a = 0; a < NADDR; a++) begin
      if (int'(sel) == NDATA + a) nxt.ax[a] = wdata[DW-1:0];
    end
    if (int'(sel) == NDATA + NADDR) nxt.fb = wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= nxt;
  end

  assign q = q_r;

  // R10: an idle write port leaves the bank untouched
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q_r));

  // R3: low byte write keeps the high byte and stores the data byte
  p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_D0 && sz == SZ_LO) |=>
      (q_r.d[0][2*BW-1:BW] == $past(q_r.d[0][2*BW-1:BW])) &&
      (q_r.d[0][BW-1:0] == $past(wdata[BW-1:0])));

  // R4: a pair write on D0 lands in D2 and D0 together
  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_D0 && sz == SZ_PAIR) |=>
      ({q_r.d[2], q_r.d[0]} == $past(wdata)));
endmodule

// File: rtl/rf_shared.sv
module rf_shared
  import rf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   pc_rst,
  input  logic            we,
  input  logic [SELW-1:0] sel,
  input  logic [AW-1:0]   wdata,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   itab,
  output logic [DW-1:0]   ustk,
  output logic [DW-1:0]   istk,
  output logic [DW-1:0]   sp,
  output logic [DW-1:0]   sb,
  output logic [DW-1:0]   flg
);
  logic [AW-1:0] pc_q,   pc_d;
  logic          boot_q;
  logic          pc_en;
  logic [AW-1:0] itab_q, itab_d;
  logic [DW-1:0] ustk_q, ustk_d;
  logic [DW-1:0] istk_q, istk_d;
  logic [DW-1:0] sb_q,   sb_d;
  logic [DW-1:0] flg_q,  flg_d;
  logic          use_ustk;
  rsel_e         s;

  assign s        = rsel_e'(sel);
  assign use_ustk = flg_q[FLG_USTK];

  always_comb begin
    itab_d = itab_q;
    ustk_d = ustk_q;
    istk_d = istk_q;
    sb_d   = sb_q;
    flg_d  = flg_q;
    pc_d   = boot_q ? pc_q : pc_rst;
    if (we) begin
      case (s)
        SEL_PC:   pc_d               = wdata;
        SEL_ITBH: itab_d[AW-1:DW]    = wdata[ITBH_W-1:0];
        SEL_ITBL: itab_d[DW-1:0]     = wdata[DW-1:0];
        SEL_SP: begin
          if (use_ustk) ustk_d = wdata[DW-1:0];
          else          istk_d = wdata[DW-1:0];
        end
        SEL_USTK: ustk_d = wdata[DW-1:0];
        SEL_ISTK: istk_d = wdata[DW-1:0];
        SEL_SB:   sb_d   = wdata[DW-1:0];
        SEL_FLG:  flg_d  = wdata[DW-1:0] & FLG_MASK;
        default: ;
      endcase
    end
  end

  assign pc_en = !boot_q || (we && s == SEL_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      boot_q <= 1'b0;
    end else if (pc_en) begin
      pc_q   <= pc_d;
      boot_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itab_q <= '0;
      ustk_q <= '0;
      istk_q <= '0;
      sb_q   <= '0;
      flg_q  <= '0;
    end else if (we) begin
      itab_q <= itab_d;
      ustk_q <= ustk_d;
      istk_q <= istk_d;
      sb_q   <= sb_d;
      flg_q  <= flg_d;
    end
  end

  assign pc   = boot_q ? pc_q : pc_rst;
  assign itab = itab_q;
  assign ustk = ustk_q;
  assign istk = istk_q;
  assign sb   = sb_q;
  assign flg  = flg_q;
  assign sp   = use_ustk ? ustk_q : istk_q;

  // R6: with the select bit clear the active pointer write spares the user pointer
  p_sp_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && s == SEL_SP && !use_ustk) |=> $stable(ustk_q));

  // R7: reserved flag positions never hold a one
  p_flag_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg & ~FLG_MASK) == '0);

  // R10: an idle write port leaves the shared state unchanged
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && boot_q) |=> ($stable(pc) && $stable(flg) && $stable(sb) && $stable(itab)));
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
  import rf_pkg::*;
(
  input  logic [SELW-1:0] sel,
  input  logic [SZW-1:0]  size,
  input  bank_t           act,
  input  logic [AW-1:0]   pc,
  input  logic [AW-1:0]   itab,
  input  logic [DW-1:0]   sp,
  input  logic [DW-1:0]   ustk,
  input  logic [DW-1:0]   istk,
  input  logic [DW-1:0]   sb,
  input  logic [DW-1:0]   flg,
  output logic [RDW-1:0]  rdata
);
  rsize_e sz;
  rsel_e  s;

  assign sz = rsize_e'(size);
  assign s  = rsel_e'(sel);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NDATA; i++) begin
      if (int'(sel) == i) begin
        if (i < NBYTE && sz == SZ_LO)
          rdata = {{(RDW-BW){1'b0}}, act.d[i][BW-1:0]};
        else if (i < NBYTE && sz == SZ_HI)
          rdata = {{(RDW-BW){1'b0}}, act.d[i][2*BW-1:BW]};
        else if (i < NBYTE && sz == SZ_PAIR)
          rdata = {act.d[(i + NBYTE) % NDATA], act.d[i]};
        else
          rdata = {{(RDW-DW){1'b0}}, act.d[i]};
      end
    end
    for (int a = 0; a < NADDR; a++) begin
      if (int'(sel) == NDATA + a) rdata = {{(RDW-DW){1'b0}}, act.ax[a]};
    end
    case (s)
      SEL_FB:   rdata = {{(RDW-DW){1'b0}}, act.fb};
      SEL_PC:   rdata = {{(RDW-AW){1'b0}}, pc};
      SEL_ITBH: rdata = {{(RDW-ITBH_W){1'b0}}, itab[AW-1:DW]};
      SEL_ITBL: rdata = {{(RDW-DW){1'b0}}, itab[DW-1:0]};
      SEL_SP:   rdata = {{(RDW-DW){1'b0}}, sp};
      SEL_USTK: rdata = {{(RDW-DW){1'b0}}, ustk};
      SEL_ISTK: rdata = {{(RDW-DW){1'b0}}, istk};
      SEL_SB:   rdata = {{(RDW-DW){1'b0}}, sb};
      SEL_FLG:  rdata = {{(RDW-DW){1'b0}}, flg};
      default: ;
    endcase
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   pc_rst_val,
  input  logic [SELW-1:0] ra_sel,
  input  logic [SZW-1:0]  ra_size,
  output logic [RDW-1:0]  ra_data,
  input  logic [SELW-1:0] rb_sel,
  input  logic [SZW-1:0]  rb_size,
  output logic [RDW-1:0]  rb_data,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [SZW-1:0]  wr_size,
  input  logic [RDW-1:0]  wr_data,
  output logic [DW-1:0]   flag_o,
  output logic [AW-1:0]   pc_o
);
  localparam int NPORT = 2;

  logic          srst_n;
  logic          act_bank;
  logic          banked_tgt;
  logic          shared_we;
  bank_t         bank_q [NBANK];
  bank_t         act;
  logic [AW-1:0] pc, itab;
  logic [DW-1:0] ustk, istk, sp, sb, flg;
  logic [SELW-1:0] rsel  [NPORT];
  logic [SZW-1:0]  rsize [NPORT];
  logic [RDW-1:0]  rdat  [NPORT];

  rf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign act_bank   = flg[FLG_BANK];
  assign banked_tgt = int'(wr_sel) <= NDATA + NADDR;
  assign shared_we  = wr_en && !banked_tgt;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && banked_tgt && (act_bank == b[0]);

    rf_bank u_bank (
      .clk   (clk),
      .rst_n (srst_n),
      .we    (bank_we),
      .sel   (wr_sel),
      .size  (wr_size),
      .wdata (wr_data),
      .q     (bank_q[b])
    );

    // R5: a bank that is not selected keeps its contents during writes
    p_bank_iso_r5: assert property (@(posedge clk) disable iff (!srst_n)
      (wr_en && act_bank != b[0]) |=> $stable(bank_q[b]));
  end

  assign act = bank_q[act_bank];

  rf_shared u_shared (
    .clk    (clk),
    .rst_n  (srst_n),
    .pc_rst (pc_rst_val),
    .we     (shared_we),
    .sel    (wr_sel),
    .wdata  (wr_data[AW-1:0]),
    .pc     (pc),
    .itab   (itab),
    .ustk   (ustk),
    .istk   (istk),
    .sp     (sp),
    .sb     (sb),
    .flg    (flg)
  );

  assign rsel[0]  = ra_sel;
  assign rsize[0] = ra_size;
  assign rsel[1]  = rb_sel;
  assign rsize[1] = rb_size;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    rf_read_mux u_mux (
      .sel   (rsel[p]),
      .size  (rsize[p]),
      .act   (act),
      .pc    (pc),
      .itab  (itab),
      .sp    (sp),
      .ustk  (ustk),
      .istk  (istk),
      .sb    (sb),
      .flg   (flg),
      .rdata (rdat[p])
    );
  end

  assign ra_data = rdat[0];
  assign rb_data = rdat[1];
  assign flag_o  = flg;
  assign pc_o    = pc;

  // R8: a bank-bit change leaves reads in the write cycle on the old bank
  p_bank_switch_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_sel == SEL_FLG) |=> (act_bank == $past(wr_data[FLG_BANK])));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int CLK_P = 10;

  localparam logic [3:0] D0 = 4'd0, D1 = 4'd1, D2 = 4'd2, D3 = 4'd3;
  localparam logic [3:0] AX0 = 4'd4, PCR = 4'd7, ITBH = 4'd8, ITBL = 4'd9;
  localparam logic [3:0] SP = 4'd10, USTK = 4'd11, ISTK = 4'd12, SB = 4'd13;
  localparam logic [3:0] FLG = 4'd14, NONE = 4'd15;
  localparam logic [1:0] WD = 2'd0, LO = 2'd1, HI = 2'd2, PR = 2'd3;
  localparam logic [19:0] PC_START = 20'h12345;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] pc_rst_val;
  logic [3:0]  ra_sel, rb_sel, wr_sel;
  logic [1:0]  ra_size, rb_size, wr_size;
  logic [31:0] ra_data, rb_data, wr_data;
  logic        wr_en;
  logic [15:0] flag_o;
  logic [19:0] pc_o;

  typedef struct {
    int          port;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  banked_regfile u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_rst_val (pc_rst_val),
    .ra_sel     (ra_sel),
    .ra_size    (ra_size),
    .ra_data    (ra_data),
    .rb_sel     (rb_sel),
    .rb_size    (rb_size),
    .rb_data    (rb_data),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_size    (wr_size),
    .wr_data    (wr_data),
    .flag_o     (flag_o),
    .pc_o       (pc_o)
  );

  task automatic step(input logic we, input logic [3:0] ws, input logic [1:0] wz,
                      input logic [31:0] wd, input logic [3:0] as, input logic [1:0] az,
                      input logic [3:0] bs, input logic [1:0] bz);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    ra_sel = as; ra_size = az; rb_sel = bs; rb_size = bz;
  endtask

  task automatic expect_on(input int port, input logic [31:0] v, input string tag);
    item_t it;
    it.port = port; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = (it.port == 0) ? ra_data : (it.port == 1) ? rb_data : {16'h0, flag_o};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pc_rst_val = PC_START;
    wr_en = 1'b0; wr_sel = D0; wr_size = WD; wr_data = '0;
    ra_sel = D0; ra_size = WD; rb_sel = D0; rb_size = WD;
    repeat (3) @(posedge clk);
    step(0, D0, WD, 0, D0, WD, PCR, WD);
    expect_on(0, 32'h0, "R1 reset d0");
    expect_on(1, 32'h12345, "R1 reset pc");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(0, D0, WD, 0, D0, WD, PCR, WD);
    expect_on(0, 32'h0, "R1 d0 after release");
    expect_on(1, 32'h12345, "R1 pc after release");
    expect_on(2, 32'h0, "R1 flags after release");

    step(1, D0, WD, 32'h0000A55A, D0, WD, SB, WD);
    expect_on(0, 32'h0, "R8 read during write d0");
    expect_on(1, 32'h0, "R1 sb zero");
    step(1, D1, WD, 32'h00001111, D0, WD, D1, WD);
    expect_on(0, 32'h0000A55A, "R2 word d0");
    expect_on(1, 32'h0, "R8 read during write d1");
    step(1, D0, LO, 32'hFFFFFF3C, D1, WD, D1, WD);
    expect_on(0, 32'h00001111, "R2 word d1");
    step(1, D0, HI, 32'h00000077, D0, WD, D0, HI);
    expect_on(0, 32'h0000A53C, "R3 low byte write");
    expect_on(1, 32'h000000A5, "R3 high byte read");
    step(1, D0, PR, 32'hDEADBEEF, D0, WD, D0, LO);
    expect_on(0, 32'h0000773C, "R3 high byte write");
    expect_on(1, 32'h0000003C, "R3 low byte read");
    step(1, D1, PR, 32'h01234567, D2, WD, D0, PR);
    expect_on(0, 32'h0000DEAD, "R4 pair upper d2");
    expect_on(1, 32'hDEADBEEF, "R4 pair read d0");
    step(1, D2, LO, 32'h0000ABCD, D1, PR, D3, WD);
    expect_on(0, 32'h01234567, "R4 pair read d1");
    expect_on(1, 32'h00000123, "R4 pair upper d3");
    step(1, FLG, WD, 32'h0000FFFF, D2, WD, D0, WD);
    expect_on(0, 32'h0000ABCD, "R3 byte size on d2 acts as word");
    expect_on(1, 32'h0000BEEF, "R8 bank switch not yet visible");
    step(1, AX0, WD, 32'h00005555, FLG, WD, D0, WD);
    expect_on(0, 32'h000070FF, "R7 reserved flag bits masked");
    expect_on(1, 32'h0, "R5 bank one d0 empty");
    expect_on(2, 32'h000070FF, "R7 flag_o");
    step(1, SP, WD, 32'h00000BEE, AX0, WD, SP, WD);
    expect_on(0, 32'h00005555, "R5 bank one ax0");
    expect_on(1, 32'h0, "R6 active sp user");
    step(1, SB, WD, 32'h00004242, USTK, WD, ISTK, WD);
    expect_on(0, 32'h00000BEE, "R6 sp write to user pointer");
    expect_on(1, 32'h0, "R6 interrupt pointer untouched");
    step(1, FLG, WD, 32'h00000000, SP, WD, D0, HI);
    expect_on(0, 32'h00000BEE, "R8 stack switch not yet visible");
    expect_on(1, 32'h0, "R5 bank one d0 high byte");
    step(1, SP, WD, 32'h00000AAA, D0, WD, AX0, WD);
    expect_on(0, 32'h0000BEEF, "R5 bank zero kept d0");
    expect_on(1, 32'h0, "R5 bank zero ax0 untouched");
    step(1, PCR, WD, 32'hFFFFFFFF, ISTK, WD, USTK, WD);
    expect_on(0, 32'h00000AAA, "R6 sp write to interrupt pointer");
    expect_on(1, 32'h00000BEE, "R6 user pointer kept");
    step(1, ITBH, WD, 32'h0000FFFF, PCR, WD, SB, WD);
    expect_on(0, 32'h000FFFFF, "R2 pc 20 bits");
    expect_on(1, 32'h00004242, "R9 sb shared across banks");
    step(1, ITBL, WD, 32'h00001234, ITBH, WD, SB, WD);
    expect_on(0, 32'h0000000F, "R2 table upper 4 bits");
    step(0, D0, WD, 32'h00000000, ITBL, WD, ITBH, WD);
    expect_on(0, 32'h00001234, "R2 table lower");
    expect_on(1, 32'h0000000F, "R2 table upper kept");
    step(0, D0, WD, 32'h0, D0, WD, NONE, WD);
    expect_on(0, 32'h0000BEEF, "R10 disabled write ignored");
    expect_on(1, 32'h0, "R2 unused select reads zero");
    step(1, NONE, WD, 32'hFFFFFFFF, D1, WD, FLG, WD);
    expect_on(0, 32'h00004567, "R4 d1 low of pair");
    step(0, D0, WD, 32'h0, D3, WD, FLG, WD);
    expect_on(0, 32'h00000123, "R2 unused select write ignored d3");
    expect_on(1, 32'h0, "R2 unused select write ignored flags");
    step(0, D0, WD, 32'h0, ISTK, WD, SB, WD);
    expect_on(0, 32'h00000AAA, "R2 unused select write ignored istk");
    expect_on(1, 32'h00004242, "R10 sb kept");

    repeat (2) @(negedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule